// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects hardware interrupt events into a bank of seven word-wide registers. Every interrupt source owns a single bit index, and that index means the same source in every register of the bank. A one-cycle event pulse latches into a cause register. A mask register suppresses selected causes. The unsuppressed causes are ORed into one interrupt line.

Software reaches the bank through a simple synchronous port with a write strobe, a read strobe, a word address and data. Read data is combinational from the address. Register updates take effect at the clock edge that ends the access. Each cause bit has its own control bit, which selects how that bit is cleared. A control bit of 0 makes the cause bit clear when software writes a one to it. A control bit of 1 makes it clear when software reads it. Separate set and clear aliases let software change the cause and the mask without a read-modify-write.

The design is built from three pieces: an address decoder, a cause/control register pair, and a mask register. The top module contains the read multiplexer. None of these holds sequencing state. The block is a flat register bank with no controller state machine, so the brief names no states or transitions.

Top module: `irqbank_top`

## Requirements
- R1: After reset the cause and control registers are all zero, the mask register is all ones, and `irq_out` is low.
- R2: Word addresses are 0 control, 1 cause, 2 masked cause, 3 cause set, 4 mask, 5 mask set, 6 mask clear, and 7 reserved. Reads of addresses 3, 5, 6 and 7 return zero. Writes to address 7 have no effect.
- R3: A high bit of `hw_events` sets the matching cause bit at the next clock edge. The bit then stays set until it is cleared.
- R4: When a control bit is 0, writing 1 to that bit of the cause register clears it. Writing 0 leaves it unchanged. Cause bits whose control bit is 1 ignore writes.
- R5: A read of the cause register returns the contents before any clear. At the end of the read, exactly the cause bits whose control bit is 1 are cleared.
- R6: The masked-cause register reads as cause AND NOT mask.
- R7: Accesses to the masked-cause register follow the same per-bit clearing rules as R4 and R5. They act on the underlying cause bit, and only for bits whose mask bit is 0.
- R8: Writing 1 to a bit of the cause-set register sets that cause bit, whatever its control bit.
- R9: A write to the mask register loads it directly. Writing 1 to a bit of mask set sets that mask bit. Writing 1 to a bit of mask clear clears it. Zero bits in either alias leave the mask unchanged.
- R10: An event on a bit in the same cycle as a clear of that bit wins, so the bit stays set. This holds for clears by write and for clears by read.
- R11: `irq_out` is the OR of all masked-cause bits. It follows the registers, so it changes in the cycle after the edge that updates them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the access in this cycle |
| reg_rd | input | 1 | Read strobe; enables clear-on-read side effects |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Read data, combinational from `reg_addr` |
| hw_events | input | WIDTH | Hardware event pulses, one per source |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench builds the bank with WIDTH set to 8, so each control pattern and each mask pattern is one of only 256 values. It sweeps all 256 control values. For each one it fills the cause, loads a derived mask and performs reads and write-clears through both the cause and the masked views. This covers every mix of write-one-to-clear and clear-on-read bits against masked and unmasked bits. Targeted sequences then cover the reset state, the reserved and write-only addresses, the mask aliases, and events that coincide with either kind of clear.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_CAUSE  = 3'd1,
        RA_MASKED = 3'd2,
        RA_SET    = 3'd3,
        RA_MASK   = 3'd4,
        RA_MSET   = 3'd5,
        RA_MCLR   = 3'd6,
        RA_RSVD   = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/irqbank_decode.sv
module irqbank_decode
    import irqbank_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  ctl,
    input  logic [WIDTH-1:0]  mask,
    output logic              ctl_we,
    output logic [WIDTH-1:0]  cause_clr,
    output logic [WIDTH-1:0]  cause_set,
    output logic              mask_we,
    output logic              mask_set_we,
    output logic              mask_clr_we
);
    reg_addr_e    sel;
    logic [WIDTH-1:0] w1c_clr;
    logic [WIDTH-1:0] cor_clr;

    always_comb begin
        sel         = reg_addr_e'(addr);
        w1c_clr     = '0;
        cor_clr     = '0;
        cause_set   = '0;
        ctl_we      = 1'b0;
        mask_we     = 1'b0;
        mask_set_we = 1'b0;
        mask_clr_we = 1'b0;
        if (wr) begin
            unique case (sel)
                RA_CTRL:   ctl_we      = 1'b1;
                RA_CAUSE:  w1c_clr     = wdata & ~ctl;
                RA_MASKED: w1c_clr     = wdata & ~ctl & ~mask;
                RA_SET:    cause_set   = wdata;
                RA_MASK:   mask_we     = 1'b1;
                RA_MSET:   mask_set_we = 1'b1;
                RA_MCLR:   mask_clr_we = 1'b1;
                RA_RSVD:   ;
            endcase
        end
        if (rd) begin
            unique case (sel)
                RA_CAUSE:  cor_clr = ctl;
                RA_MASKED: cor_clr = ctl & ~mask;
                default:   cor_clr = '0;
            endcase
        end
        cause_clr = w1c_clr | cor_clr;
    end
endmodule

// File: rtl/irqbank_cause.sv
module irqbank_cause #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [WIDTH-1:0] ctl_wd,
    input  logic [WIDTH-1:0] cause_clr,
    input  logic [WIDTH-1:0] cause_set,
    input  logic [WIDTH-1:0] events,
    output logic [WIDTH-1:0] ctl,
    output logic [WIDTH-1:0] cause
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl   <= '0;
            cause <= '0;
        end else begin
            if (ctl_we) ctl <= ctl_wd;
            cause <= (cause & ~cause_clr) | cause_set | events;
        end
    end

    p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause & $past(events)) == $past(events)));

    p_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_clr != '0) |=> ((cause & $past(cause_clr & ~events & ~cause_set)) == '0));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_clr == '0) |=> ((cause & $past(cause)) == $past(cause)));

    p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_set != '0) |=> ((cause & $past(cause_set)) == $past(cause_set)));
endmodule

// File: rtl/irqbank_mask.sv
module irqbank_mask #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic             mask_set_we,
    input  logic             mask_clr_we,
    input  logic [WIDTH-1:0] wd,
    output logic [WIDTH-1:0] mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           mask <= '1;
        else if (mask_we)     mask <= wd;
        else if (mask_set_we) mask <= mask | wd;
        else if (mask_clr_we) mask <= mask & ~wd;
    end

    p_mask_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set_we |=> ((mask & $past(wd)) == $past(wd)));

    p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_clr_we |=> ((mask & $past(wd)) == '0));

    p_mask_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_set_we || mask_clr_we) |=> ((mask & ~$past(wd)) == ($past(mask) & ~$past(wd))));
endmodule

// File: rtl/irqbank_top.sv
module irqbank_top
    import irqbank_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WIDTH-1:0]  reg_wdata,
    output logic [WIDTH-1:0]  reg_rdata,
    input  logic [WIDTH-1:0]  hw_events,
    output logic              irq_out
);
    logic [WIDTH-1:0] ctl, cause, mask, masked;
    logic [WIDTH-1:0] cause_clr, cause_set;
    logic             ctl_we, mask_we, mask_set_we, mask_clr_we;

    irqbank_decode #(.WIDTH(WIDTH)) u_decode (
        .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .wdata(reg_wdata),
        .ctl(ctl), .mask(mask), .ctl_we(ctl_we), .cause_clr(cause_clr),
        .cause_set(cause_set), .mask_we(mask_we), .mask_set_we(mask_set_we),
        .mask_clr_we(mask_clr_we)
    );

    irqbank_cause #(.WIDTH(WIDTH)) u_cause (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wd(reg_wdata),
        .cause_clr(cause_clr), .cause_set(cause_set), .events(hw_events),
        .ctl(ctl), .cause(cause)
    );

    irqbank_mask #(.WIDTH(WIDTH)) u_mask (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_set_we(mask_set_we),
        .mask_clr_we(mask_clr_we), .wd(reg_wdata), .mask(mask)
    );

    assign masked  = cause & ~mask;
    assign irq_out = |masked;

    always_comb begin
        unique case (reg_addr_e'(reg_addr))
            RA_CTRL:   reg_rdata = ctl;
            RA_CAUSE:  reg_rdata = cause;
            RA_MASKED: reg_rdata = masked;
            RA_MASK:   reg_rdata = mask;
            default:   reg_rdata = '0;
        endcase
    end

    p_all_masked_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq_out);

    p_wo_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_SET || reg_addr == RA_MSET || reg_addr == RA_MCLR
         || reg_addr == RA_RSVD) |-> (reg_rdata == '0));

    p_cor_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == RA_CAUSE && hw_events == '0)
        |=> ((cause & $past(ctl)) == '0));
endmodule

// File: tb/irqbank_top_bench.sv
module irqbank_top_bench;
    localparam int W = 8;
    localparam time PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [W-1:0] reg_wdata = '0, hw_events = '0;
    logic [W-1:0] reg_rdata;
    logic         irq_out;

    int checks = 0, errors = 0;
    logic [W-1:0] m_ctl, m_cause, m_mask;

    always #(PERIOD/2) clk = ~clk;

    irqbank_top #(.WIDTH(W)) u_irqbank_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_events(hw_events), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_ctl;
            3'd1: return m_cause;
            3'd2: return m_cause & ~m_mask;
            3'd4: return m_mask;
            default: return '0;
        endcase
    endfunction

    // one access cycle; compares read data and irq, then advances the model
    task automatic op(input string req, input bit wr, input bit rd, input logic [2:0] a,
                      input logic [W-1:0] wd, input logic [W-1:0] ev);
        logic [W-1:0] clr, set, nmask;
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd; hw_events = ev;
        #1;
        check({req, " R11 irq"}, W'(irq_out), W'(|(m_cause & ~m_mask)));
        if (rd) check(req, reg_rdata, model_read(a));
        clr = '0; set = '0; nmask = m_mask;
        if (wr) case (a)
            3'd1: clr = wd & ~m_ctl;
            3'd2: clr = wd & ~m_ctl & ~m_mask;
            3'd3: set = wd;
            3'd4: nmask = wd;
            3'd5: nmask = m_mask | wd;
            3'd6: nmask = m_mask & ~wd;
            default: ;
        endcase
        if (rd) case (a)
            3'd1: clr = clr | m_ctl;
            3'd2: clr = clr | (m_ctl & ~m_mask);
            default: ;
        endcase
        @(posedge clk);
        if (wr && a == 3'd0) m_ctl = wd;
        m_cause = (m_cause & ~clr) | set | ev;
        m_mask = nmask;
        #1;
        reg_wr = 0; reg_rd = 0; hw_events = '0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        m_ctl = '0; m_cause = '0; m_mask = '1;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 irq", W'(irq_out), '0);
        reg_addr = 3'd0; #1; check("R1 ctrl", reg_rdata, '0);
        reg_addr = 3'd1; #1; check("R1 cause", reg_rdata, '0);
        reg_addr = 3'd4; #1; check("R1 mask", reg_rdata, '1);
        rst_n = 1'b1;
        // R3 events latch and stay
        op("R3", 0, 0, 3'd0, '0, 8'h81);
        op("R3 sticky", 0, 1, 3'd1, '0, '0);
        op("R3 sticky", 0, 1, 3'd1, '0, '0);
        // R2 write-only and reserved reads zero, reserved write ignored
        op("R2 set rd", 0, 1, 3'd3, '0, '0);
        op("R2 mset rd", 0, 1, 3'd5, '0, '0);
        op("R2 mclr rd", 0, 1, 3'd6, '0, '0);
        op("R2 rsvd wr", 1, 0, 3'd7, 8'hFF, '0);
        op("R2 rsvd rd", 0, 1, 3'd7, '0, '0);
        op("R2 after rsvd", 0, 1, 3'd1, '0, '0);
        op("R2 after rsvd", 0, 1, 3'd4, '0, '0);
        // R9 mask aliases
        op("R9", 1, 0, 3'd4, 8'h0F, '0);
        op("R9 direct", 0, 1, 3'd4, '0, '0);
        op("R9", 1, 0, 3'd5, 8'h30, '0);
        op("R9 set", 0, 1, 3'd4, '0, '0);
        op("R9", 1, 0, 3'd6, 8'h05, '0);
        op("R9 clear", 0, 1, 3'd4, '0, '0);
        op("R6 masked", 0, 1, 3'd2, '0, '0);
        // R10 event beats W1C clear and COR clear
        op("R10", 1, 0, 3'd0, 8'hF0, '0);
        op("R10", 1, 0, 3'd3, 8'hFF, '0);
        op("R10 w1c", 1, 0, 3'd1, 8'h0F, 8'h01);
        op("R10 w1c", 0, 1, 3'd0, '0, '0);
        op("R10 after w1c", 1, 0, 3'd4, 8'h00, '0);
        op("R10 cor", 0, 1, 3'd1, '0, 8'h80);
        op("R10 after cor", 0, 1, 3'd1, '0, '0);
        op("R4", 1, 0, 3'd1, 8'hFF, '0);
        op("R4 after", 0, 1, 3'd1, '0, '0);
        // sweep every control pattern against a derived mask
        for (int i = 0; i < 256; i++) begin
            op("R8", 1, 0, 3'd0, W'(i), '0);
            op("R8", 1, 0, 3'd3, 8'hFF, '0);
            op("R8 set", 0, 1, 3'd1, '0, '0);
            op("R9", 1, 0, 3'd4, W'(i) ^ 8'h5A, '0);
            op("R6 R7 masked cor", 0, 1, 3'd2, '0, '0);
            op("R7 w1c", 1, 0, 3'd2, 8'hFF, '0);
            op("R5 cor", 0, 1, 3'd1, '0, '0);
            op("R5 after cor", 0, 1, 3'd1, '0, '0);
            op("R4 w1c", 1, 0, 3'd1, 8'hFF, '0);
            op("R4 after w1c", 0, 1, 3'd1, '0, '0);
            op("R11", 1, 0, 3'd3, W'(i), '0);
            op("R11", 1, 0, 3'd6, 8'hFF, '0);
            op("R11 empty", 0, 1, 3'd2, '0, '0);
            op("R1 ctrl", 0, 1, 3'd0, '0, '0);
            op("R4", 1, 0, 3'd0, '0, '0);
            op("R4", 1, 0, 3'd1, 8'hFF, '0);
        end
        finish_run();
    end
endmodule